// File: doc/BRIEF.md
# SDRAM Device-Side Command Front End

This block sits at the pin side of a four-bank single-data-rate SDRAM model. On every rising clock edge it samples chip select, the three command strobes, clock enable, the bank select and the multiplexed address bus. It turns the sampled pattern into a single command pulse, and it latches the bank, row, column or mode-word fields that the command carries. The storage array and the refresh engine downstream act on these outputs, so they never have to decode raw pins.

The block also keeps a per-bank open/closed vector, which gives an all-idle flag. Clock enable is handled as the device expects. When it is sampled low, the front end freezes from the following edge. If no bank is open at that point, it reports power-down. Data-mask handling is also here. The write mask applies to the data sampled at the same edge as the mask bit. The read mask reaches the output two edges after the mask bit is sampled. No data stream passes through the block, so every pin is a plain control or status signal and there is no back-pressure.

Top module: `sdr_cmd_front`

## Requirements
- R1: With chip select high at an accepted edge, no command strobe rises after that edge. The other command pins and the address are ignored, and the latched fields keep their values.
- R2: With chip select low and the three command strobes high (NOP), no strobe rises and the latched fields hold.
- R3: The `{cs_n,ras_n,cas_n,we_n}` patterns decode as follows: 0011 is activate (cmd_o bit 0), 0101 is read (bit 1), 0100 is write (bit 2) and 0010 is precharge (bit 3). 0000 with bank select other than 2'b10 is a mode write (bit 4), and 0000 with bank select 2'b10 is an extended mode write (bit 5). The strobe is high for exactly the one cycle after the accepting edge, and at most one bit is ever set. After reset all strobes, fields and status outputs are zero.
- R4: A mode write or an extended mode write copies the full address bus into mode_o.
- R5: Activate latches bank_o and row_o (address bits 12..0). Read and write latch bank_o and col_o (address bits 8..0). Precharge latches bank_o only.
- R6: Activate sets the open bit of the addressed bank and precharge clears it. all_idle_o is high exactly when no bit is set.
- R7: A command sampled with clock enable low is still accepted. At every later edge where clock enable is still low, all inputs (mask included) are ignored: strobes stay low, fields, bank vector and masks hold, and suspended_o is high.
- R8: The first edge that samples clock enable high again accepts its command and clears suspended_o.
- R9: power_down_o rises only when clock enable is sampled low at an accepted edge and every bank is closed after that edge's command. It stays high while clock enable stays low and falls at the edge that samples it high.
- R10: wr_mask_o after an accepted edge equals the mask input sampled at that same edge.
- R11: rd_mask_o after accepted edge k+2 equals the mask input sampled at accepted edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_i | input | 1 | Clock enable |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank select |
| addr_i | input | 13 | Multiplexed address |
| dqm_i | input | 1 | Data mask |
| cmd_o | output | 6 | One-hot command strobes |
| bank_o | output | 2 | Latched bank |
| row_o | output | 13 | Latched row |
| col_o | output | 9 | Latched column |
| mode_o | output | 13 | Latched mode word |
| banks_open_o | output | 4 | Per-bank open vector |
| all_idle_o | output | 1 | No bank open |
| suspended_o | output | 1 | Input sampling frozen |
| power_down_o | output | 1 | Frozen with all banks idle |
| wr_mask_o | output | 1 | Write data mask |
| rd_mask_o | output | 1 | Read data mask |

## Verification
A wrong open vector shows at banks_open_o and all_idle_o in the cycle right after the faulty activate or precharge. One edge later it also shows as a wrong power_down_o when clock enable drops. A suspend flag that is stuck or off by one cycle shows at once: a strobe appears after an edge that should be ignored, or an accepted command is lost when clock enable returns. A mask pipeline of the wrong depth shows as rd_mask_o rising one edge early or late relative to the mask pulse.

// File: rtl/sdr_cmd_pkg.sv
package sdr_cmd_pkg;
  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_MRS  = 3'd5,
    CMD_EMRS = 3'd6
  } cmd_e;

  localparam int STB_W = 6;  // strobe bit i <=> cmd_e value i+1
endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
  import sdr_cmd_pkg::*;
#(
  parameter int BA_W = 2
) (
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic [BA_W-1:0] ba,
  output cmd_e            cmd
);
  localparam logic [BA_W-1:0] EXT_SEL = BA_W'(2);

  always_comb begin
    cmd = CMD_NONE;
    if (!cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b000:  cmd = (ba == EXT_SEL) ? CMD_EMRS : CMD_MRS;
        default: cmd = CMD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/sdr_bank_track.sv
module sdr_bank_track #(
  parameter int NUM_BANKS = 4,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 act,
  input  logic                 pre,
  input  logic [BA_W-1:0]      ba,
  output logic [NUM_BANKS-1:0] open_q,
  output logic                 idle_next
);
  logic [NUM_BANKS-1:0] open_d;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_comb begin
      open_d[b] = open_q[b];
      if (act && ba == BA_W'(b)) open_d[b] = 1'b1;
      if (pre && ba == BA_W'(b)) open_d[b] = 1'b0;
    end
  end

  assign idle_next = (open_d == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= '0;
    else        open_q <= open_d;
  end
endmodule

// File: rtl/sdr_dqm_pipe.sv
module sdr_dqm_pipe #(
  parameter int RD_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic dqm,
  output logic wr_mask,
  output logic rd_mask
);
  logic [RD_LAT:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  stage_q[0] <= 1'b0;
    else if (en) stage_q[0] <= dqm;
  end

  for (genvar s = 1; s <= RD_LAT; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  stage_q[s] <= 1'b0;
      else if (en) stage_q[s] <= stage_q[s-1];
    end
  end

  assign wr_mask = stage_q[0];
  assign rd_mask = stage_q[RD_LAT];
endmodule

// File: rtl/sdr_cmd_front.sv
module sdr_cmd_front
  import sdr_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 13,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 9,
  parameter int RD_LAT    = 2,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cke_i,
  input  logic                 cs_n_i,
  input  logic                 ras_n_i,
  input  logic                 cas_n_i,
  input  logic                 we_n_i,
  input  logic [BA_W-1:0]      ba_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 dqm_i,
  output logic [STB_W-1:0]     cmd_o,
  output logic [BA_W-1:0]      bank_o,
  output logic [ROW_W-1:0]     row_o,
  output logic [COL_W-1:0]     col_o,
  output logic [ADDR_W-1:0]    mode_o,
  output logic [NUM_BANKS-1:0] banks_open_o,
  output logic                 all_idle_o,
  output logic                 suspended_o,
  output logic                 power_down_o,
  output logic                 wr_mask_o,
  output logic                 rd_mask_o
);
  cmd_e             dec;
  logic             accept;
  logic             idle_next;
  logic [STB_W-1:0] stb_d;

  // an edge is honoured if CKE is high now or was high at the previous edge
  assign accept = cke_i | ~suspended_o;

  sdr_cmd_decode #(.BA_W(BA_W)) i_decode (
    .cs_n (cs_n_i),
    .ras_n(ras_n_i),
    .cas_n(cas_n_i),
    .we_n (we_n_i),
    .ba   (ba_i),
    .cmd  (dec)
  );

  for (genvar i = 0; i < STB_W; i++) begin : g_stb
    assign stb_d[i] = accept && (dec == cmd_e'(i + 1));
  end

  sdr_bank_track #(.NUM_BANKS(NUM_BANKS)) i_banks (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (stb_d[0]),
    .pre      (stb_d[3]),
    .ba       (ba_i),
    .open_q   (banks_open_o),
    .idle_next(idle_next)
  );

  sdr_dqm_pipe #(.RD_LAT(RD_LAT)) i_dqm (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (accept),
    .dqm    (dqm_i),
    .wr_mask(wr_mask_o),
    .rd_mask(rd_mask_o)
  );

  assign all_idle_o = (banks_open_o == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_o        <= '0;
      bank_o       <= '0;
      row_o        <= '0;
      col_o        <= '0;
      mode_o       <= '0;
      suspended_o  <= 1'b0;
      power_down_o <= 1'b0;
    end else begin
      cmd_o       <= stb_d;
      suspended_o <= ~cke_i;
      if (cke_i)       power_down_o <= 1'b0;
      else if (accept) power_down_o <= idle_next;
      if (stb_d[0]) begin
        bank_o <= ba_i;
        row_o  <= addr_i[ROW_W-1:0];
      end
      if (stb_d[1] || stb_d[2]) begin
        bank_o <= ba_i;
        col_o  <= addr_i[COL_W-1:0];
      end
      if (stb_d[3]) bank_o <= ba_i;
      if (stb_d[4] || stb_d[5]) mode_o <= addr_i;
    end
  end
endmodule

// File: rtl/sdr_cmd_front_chk.sv
module sdr_cmd_front_chk #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int STB_W     = 6,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cke_i,
  input logic                 cs_n_i,
  input logic                 ras_n_i,
  input logic                 cas_n_i,
  input logic                 we_n_i,
  input logic [BA_W-1:0]      ba_i,
  input logic                 dqm_i,
  input logic [STB_W-1:0]     cmd_o,
  input logic [ROW_W-1:0]     row_o,
  input logic [NUM_BANKS-1:0] banks_open_o,
  input logic                 all_idle_o,
  input logic                 suspended_o,
  input logic                 power_down_o,
  input logic                 wr_mask_o
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_o)); // R3

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_i |=> (cmd_o == '0)); // R1

  AST_HOLD_IN_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended_o && !cke_i) |=> (cmd_o == '0 && $stable(row_o) && $stable(banks_open_o))); // R7

  AST_PD_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    power_down_o |-> all_idle_o); // R9

  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    ((cke_i || !suspended_o) && !cs_n_i && !ras_n_i && cas_n_i && we_n_i)
      |=> banks_open_o[$past(ba_i)]); // R6

  AST_WR_MASK_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_i || !suspended_o) |=> (wr_mask_o == $past(dqm_i))); // R10
endmodule

bind sdr_cmd_front sdr_cmd_front_chk #(
  .NUM_BANKS(NUM_BANKS),
  .ROW_W    (ROW_W),
  .STB_W    (sdr_cmd_pkg::STB_W)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cke_i       (cke_i),
  .cs_n_i      (cs_n_i),
  .ras_n_i     (ras_n_i),
  .cas_n_i     (cas_n_i),
  .we_n_i      (we_n_i),
  .ba_i        (ba_i),
  .dqm_i       (dqm_i),
  .cmd_o       (cmd_o),
  .row_o       (row_o),
  .banks_open_o(banks_open_o),
  .all_idle_o  (all_idle_o),
  .suspended_o (suspended_o),
  .power_down_o(power_down_o),
  .wr_mask_o   (wr_mask_o)
);

// File: tb/test_sdr_cmd_front.sv
module test_sdr_cmd_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke_i = 1'b1;
  logic        cs_n_i = 1'b1, ras_n_i = 1'b1, cas_n_i = 1'b1, we_n_i = 1'b1;
  logic [1:0]  ba_i = '0;
  logic [12:0] addr_i = '0;
  logic        dqm_i = 1'b0;
  logic [5:0]  cmd_o;
  logic [1:0]  bank_o;
  logic [12:0] row_o, mode_o;
  logic [8:0]  col_o;
  logic [3:0]  banks_open_o;
  logic        all_idle_o, suspended_o, power_down_o, wr_mask_o, rd_mask_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  sdr_cmd_front i_sdr_cmd_front (.*);

  localparam logic [3:0] P_NOP = 4'b0111, P_ACT = 4'b0011, P_RD = 4'b0101,
                         P_WR = 4'b0100, P_PRE = 4'b0010, P_MRS = 4'b0000,
                         P_DES = 4'b1000;

  // {pins[3:0], ba[1:0], addr[12:0], exp_cmd[5:0], exp_open[3:0]}
  localparam int NV = 13;
  localparam logic [28:0] VEC [NV] = '{
    {P_NOP, 2'd0, 13'h0000, 6'b000000, 4'b0000},  // R2
    {P_ACT, 2'd1, 13'h0123, 6'b000001, 4'b0010},  // R3 R6
    {P_ACT, 2'd3, 13'h1ABC, 6'b000001, 4'b1010},
    {P_RD,  2'd1, 13'h0044, 6'b000010, 4'b1010},
    {P_WR,  2'd3, 13'h0055, 6'b000100, 4'b1010},
    {P_DES, 2'd0, 13'h0000, 6'b000000, 4'b1010},  // R1
    {P_PRE, 2'd1, 13'h0000, 6'b001000, 4'b1000},
    {P_PRE, 2'd3, 13'h0000, 6'b001000, 4'b0000},
    {P_MRS, 2'd0, 13'h0022, 6'b010000, 4'b0000},  // R4
    {P_MRS, 2'd2, 13'h0001, 6'b100000, 4'b0000},
    {P_MRS, 2'd1, 13'h0003, 6'b010000, 4'b0000},
    {P_ACT, 2'd0, 13'h0007, 6'b000001, 4'b0001},
    {P_PRE, 2'd0, 13'h0000, 6'b001000, 4'b0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive pins, let one rising edge sample them, return 1 ns after the edge
  task automatic step(input logic cke, input logic [3:0] pins, input logic [1:0] ba,
                      input logic [12:0] addr, input logic dqm);
    cke_i = cke;
    {cs_n_i, ras_n_i, cas_n_i, we_n_i} = pins;
    ba_i = ba;
    addr_i = addr;
    dqm_i = dqm;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R3 reset cmd", 32'(cmd_o), 0);
    chk("R6 reset open", 32'(banks_open_o), 0);
    chk("R7 reset suspend", 32'(suspended_o), 0);
    chk("R9 reset pd", 32'(power_down_o), 0);
    chk("R11 reset masks", 32'({wr_mask_o, rd_mask_o}), 0);

    for (int i = 0; i < NV; i++) begin
      step(1'b1, VEC[i][28:25], VEC[i][24:23], VEC[i][22:10], 1'b0);
      chk("R3 table cmd", 32'(cmd_o), 32'(VEC[i][9:4]));
      chk("R6 table open", 32'(banks_open_o), 32'(VEC[i][3:0]));
    end
    chk("R4 mode word", 32'(mode_o), 32'h0003);

    // mask latencies
    step(1'b1, P_NOP, 2'd0, 13'h0, 1'b1);
    chk("R10 wr mask same edge", 32'(wr_mask_o), 1);
    step(1'b1, P_NOP, 2'd0, 13'h0, 1'b0);
    chk("R10 wr mask clears", 32'(wr_mask_o), 0);
    chk("R11 rd mask not yet", 32'(rd_mask_o), 0);
    step(1'b1, P_NOP, 2'd0, 13'h0, 1'b0);
    chk("R11 rd mask two edges", 32'(rd_mask_o), 1);
    step(1'b1, P_NOP, 2'd0, 13'h0, 1'b0);
    chk("R11 rd mask drops", 32'(rd_mask_o), 0);

    // field latching
    step(1'b1, P_ACT, 2'd2, 13'h1F0F, 1'b0);
    chk("R5 row", 32'(row_o), 32'h1F0F);
    chk("R5 act bank", 32'(bank_o), 2);
    step(1'b1, P_RD, 2'd2, 13'h1FF5, 1'b0);
    chk("R5 col low bits", 32'(col_o), 32'h1F5);
    chk("R5 row holds", 32'(row_o), 32'h1F0F);
    step(1'b1, P_NOP, 2'd1, 13'h0AAA, 1'b0);
    chk("R2 nop holds col", 32'(col_o), 32'h1F5);
    chk("R2 nop holds bank", 32'(bank_o), 2);

    // clock suspend with bank 2 open
    step(1'b0, P_WR, 2'd2, 13'h0011, 1'b1);
    chk("R7 last cmd accepted", 32'(cmd_o), 32'b000100);
    chk("R7 suspended", 32'(suspended_o), 1);
    chk("R9 no pd with open bank", 32'(power_down_o), 0);
    step(1'b0, P_PRE, 2'd2, 13'h0000, 1'b0);
    chk("R7 ignored cmd", 32'(cmd_o), 0);
    chk("R7 open frozen", 32'(banks_open_o), 32'b0100);
    chk("R7 mask frozen", 32'(wr_mask_o), 1);
    chk("R7 col frozen", 32'(col_o), 32'h011);
    step(1'b1, P_PRE, 2'd2, 13'h0000, 1'b0);
    chk("R8 wake accepts", 32'(cmd_o), 32'b001000);
    chk("R8 suspend clears", 32'(suspended_o), 0);
    chk("R8 bank closed", 32'(banks_open_o), 0);

    // power-down
    step(1'b0, P_NOP, 2'd0, 13'h0, 1'b0);
    chk("R9 pd entry", 32'(power_down_o), 1);
    step(1'b0, P_ACT, 2'd0, 13'h0005, 1'b0);
    chk("R9 pd holds", 32'(power_down_o), 1);
    chk("R7 pd ignores act", 32'(banks_open_o), 0);
    step(1'b1, P_NOP, 2'd0, 13'h0, 1'b0);
    chk("R9 pd exit", 32'(power_down_o), 0);

    // activate accepted on the CKE-low edge keeps the device out of power-down
    step(1'b0, P_ACT, 2'd3, 13'h0009, 1'b0);
    chk("R9 act blocks pd", 32'(power_down_o), 0);
    chk("R6 act while cke low", 32'(banks_open_o), 32'b1000);
    step(1'b1, P_PRE, 2'd3, 13'h0, 1'b0);
    chk("R6 idle again", 32'(all_idle_o), 1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule